// File: doc/BRIEF.md
# Multicycle Subset Processor Core

This block is a small processor core that runs a subset of a 32-bit load/store instruction set: five register-to-register operations, a word load, a word store and a branch-on-equal. Each instruction is split into short steps of one clock each. This lets a single arithmetic unit and a single word memory serve every step. A state controller walks each instruction through fetch, decode, execute, memory access and write-back, and leaves out the steps that a given instruction does not need. A branch takes 3 cycles, a register operation or a store takes 4, and a load takes 5.

Instructions and data share one internal word memory. Intermediate results sit in named holding registers: the instruction register, two operand latches, the ALU result latch and the load data latch. While reset is held, a loader port fills the memory. A second, read-only port lets the surrounding logic inspect any memory word at any time. The core shows its program counter and a one-cycle retire strobe.

Top module: `mc_core`

## Requirements
- R1: While reset is low, `pc` reads 0 and `retire` reads 0. After reset is released, the first fetch reads word 0.
- R2: Each fetch loads the instruction at `pc` and advances `pc` by 4. `pc` stays a multiple of 4.
- R3: A register operation has opcode bits [31:26] = 0x00. It writes rs op rt into rd, where rs = bits [25:21], rt = bits [20:16] and rd = bits [15:11]. The function field in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R4: A load (opcode 0x23) writes the memory word at rs + sign-extended bits [15:0] into rt. Negative offsets are allowed. Memory is indexed by byte-address bits [MAW+1:2].
- R5: A store (opcode 0x2B) writes register rt to the memory word at rs + sign-extended bits [15:0].
- R6: A branch (opcode 0x04) compares rs with rt. When they are equal, `pc` becomes the address of the next instruction plus the sign-extended bits [15:0] shifted left by 2. When they differ, execution continues with the next word.
- R7: Cycle counts from fetch to retire are: branch 3, register operation 4, store 4, load 5, undefined instruction 2.
- R8: Register 0 always reads as zero. Writes to it from a register operation or a load are dropped.
- R9: An undefined opcode, or a function code not listed in R3, changes no register and no memory word. Execution continues at the following word.
- R10: While reset is low, `ld_we` writes `ld_data` to memory word `ld_addr`. `pk_data` shows memory word `pk_addr` combinationally.
- R11: `retire` is high for exactly one cycle per instruction: the instruction's last cycle. The next cycle is always a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Loader write strobe, honoured only while reset is low |
| ld_addr | input | MAW | Loader word index |
| ld_data | input | 32 | Loader write data |
| pk_addr | input | MAW | Inspection word index |
| pk_data | output | 32 | Memory word at `pk_addr` |
| pc | output | 32 | Current program counter |
| retire | output | 1 | High in the final cycle of each instruction |

## Verification
On every cycle, assertions check the following: the program counter stays word-aligned and is left alone in decode, memory and write-back steps; a failed compare never moves it; a retire is followed by a fetch and never lasts two cycles; write-back is reached only from the memory step; register 0 stays zero; an undefined instruction goes straight back to fetch. Only the bench's programs can show that the arithmetic results, load and store addresses with negative offsets, taken and untaken branch targets, and total cycle counts match an independent instruction-level model. The bench runs one directed program and several random ones.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} state_t;
  typedef enum logic [2:0] {K_ALU, K_LOAD, K_STORE, K_BRANCH, K_BAD} iclass_t;
  typedef enum logic [2:0] {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT} aluop_t;
  typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM, SB_BROFF} srcb_t;

  typedef struct packed {
    logic   ir_we;
    logic   pc_we;
    logic   pc_from_aluout;
    logic   addr_from_aluout;
    logic   mem_we;
    logic   mdr_we;
    logic   ab_we;
    logic   aluout_we;
    logic   rf_we;
    logic   rf_dst_rd;
    logic   rf_from_mdr;
    logic   src_a_pc;
    srcb_t  src_b;
    aluop_t alu_op;
    logic   retire;
  } ctrl_t;

  function automatic iclass_t classify(input logic [5:0] opc, input logic [5:0] fn);
    case (opc)
      OPC_RTYPE: begin
        case (fn)
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: return K_ALU;
          default: return K_BAD;
        endcase
      end
      OPC_LOAD:  return K_LOAD;
      OPC_STORE: return K_STORE;
      OPC_BEQ:   return K_BRANCH;
      default:   return K_BAD;
    endcase
  endfunction

  function automatic aluop_t funct_op(input logic [5:0] fn);
    case (fn)
      FN_SUB:  return OP_SUB;
      FN_AND:  return OP_AND;
      FN_OR:   return OP_OR;
      FN_SLT:  return OP_SLT;
      default: return OP_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input aluop_t op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_SUB:  return a - b;
      OP_SLT:  return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: return a + b;
    endcase
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2
);
  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R8: storage slot 0 never takes a value
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/mc_mem.sv
module mc_mem #(
  parameter int WORDS = 128,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic [AW-1:0]    paddr,
  output logic [WIDTH-1:0] pdata
);
  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
  assign pdata = cells[paddr];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  input  logic       zero,
  output state_t     state,
  output ctrl_t      c
);
  state_t  nxt;
  iclass_t cls;

  assign cls = classify(opc, fn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  always_comb begin
    c        = '0;
    c.alu_op = OP_ADD;
    c.src_b  = SB_REG;
    nxt      = ST_FETCH;
    case (state)
      ST_FETCH: begin
        c.ir_we    = 1'b1;
        c.pc_we    = 1'b1;
        c.src_a_pc = 1'b1;
        c.src_b    = SB_FOUR;
        nxt        = ST_DECODE;
      end
      ST_DECODE: begin
        c.ab_we     = 1'b1;
        c.aluout_we = 1'b1;
        c.src_a_pc  = 1'b1;
        c.src_b     = SB_BROFF;
        if (cls == K_BAD) c.retire = 1'b1;
        else              nxt      = ST_EXEC;
      end
      ST_EXEC: begin
        case (cls)
          K_ALU: begin
            c.alu_op    = funct_op(fn);
            c.aluout_we = 1'b1;
            nxt         = ST_MEM;
          end
          K_LOAD, K_STORE: begin
            c.src_b     = SB_IMM;
            c.aluout_we = 1'b1;
            nxt         = ST_MEM;
          end
          K_BRANCH: begin
            c.alu_op         = OP_SUB;
            c.pc_we          = zero;
            c.pc_from_aluout = 1'b1;
            c.retire         = 1'b1;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        case (cls)
          K_ALU: begin
            c.rf_we     = 1'b1;
            c.rf_dst_rd = 1'b1;
            c.retire    = 1'b1;
          end
          K_LOAD: begin
            c.addr_from_aluout = 1'b1;
            c.mdr_we           = 1'b1;
            nxt                = ST_WB;
          end
          K_STORE: begin
            c.addr_from_aluout = 1'b1;
            c.mem_we           = 1'b1;
            c.retire           = 1'b1;
          end
          default: ;
        endcase
      end
      ST_WB: begin
        c.rf_we       = 1'b1;
        c.rf_from_mdr = 1'b1;
        c.retire      = 1'b1;
      end
      default: ;
    endcase
  end

  p_retire_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    c.retire |=> !c.retire);
  p_retire_to_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    c.retire |=> (state == ST_FETCH));
  p_wb_after_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |-> ($past(state) == ST_MEM));
  p_bad_to_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DECODE) && (cls == K_BAD)) |=> (state == ST_FETCH));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 128,
  parameter int NREGS     = 32,
  localparam int MAW = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [MAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [MAW-1:0]  pk_addr,
  output logic [XLEN-1:0] pk_data,
  output logic [XLEN-1:0] pc,
  output logic            retire
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;
  logic [XLEN-1:0] src_a, src_b, alu_y, mem_addr, mem_rdata, rf_wd, rd1, rd2;
  logic [RIDX_W-1:0] rf_wa;
  logic [MAW-1:0]    core_idx, mem_waddr;
  logic [XLEN-1:0]   mem_wdata;
  logic              mem_we, zero;
  ctrl_t             c;
  state_t            state;
  iclass_t           cls_now;

  mc_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .opc   (ir_q[31:26]),
    .fn    (ir_q[5:0]),
    .zero  (zero),
    .state (state),
    .c     (c)
  );

  // shared arithmetic unit: one adder/logic block for every step
  assign src_a = c.src_a_pc ? pc_q : a_q;
  always_comb begin
    case (c.src_b)
      SB_FOUR:  src_b = XLEN'(4);
      SB_IMM:   src_b = sext16(ir_q[15:0]);
      SB_BROFF: src_b = sext16(ir_q[15:0]) << 2;
      default:  src_b = b_q;
    endcase
  end
  assign alu_y = alu_eval(c.alu_op, src_a, src_b);
  assign zero  = (alu_y == '0);

  // single memory: instruction fetch or data access
  assign mem_addr  = c.addr_from_aluout ? aluout_q : pc_q;
  assign core_idx  = mem_addr[MAW+1:2];
  assign mem_we    = rst_n ? c.mem_we : ld_we;
  assign mem_waddr = rst_n ? core_idx : ld_addr;
  assign mem_wdata = rst_n ? b_q : ld_data;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{mem_addr[XLEN-1:MAW+2], mem_addr[1:0]};

  mc_mem #(.WORDS(MEM_WORDS), .WIDTH(XLEN)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (core_idx),
    .rdata (mem_rdata),
    .paddr (pk_addr),
    .pdata (pk_data)
  );

  assign rf_wa = c.rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = c.rf_from_mdr ? mdr_q : aluout_q;

  mc_regfile #(.NREGS(NREGS), .WIDTH(XLEN)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra1   (ir_q[25:21]),
    .ra2   (ir_q[20:16]),
    .we    (c.rf_we),
    .wa    (rf_wa),
    .wd    (rf_wd),
    .rd1   (rd1),
    .rd2   (rd2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (c.pc_we)     pc_q     <= c.pc_from_aluout ? aluout_q : alu_y;
      if (c.ir_we)     ir_q     <= mem_rdata;
      if (c.ab_we)     a_q      <= rd1;
      if (c.ab_we)     b_q      <= rd2;
      if (c.aluout_we) aluout_q <= alu_y;
      if (c.mdr_we)    mdr_q    <= mem_rdata;
    end
  end

  assign pc     = pc_q;
  assign retire = c.retire;

  assign cls_now = classify(ir_q[31:26], ir_q[5:0]);

  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);
  p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DECODE) || (state == ST_MEM) || (state == ST_WB)) |=> $stable(pc_q));
  p_beq_untaken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_EXEC) && (cls_now == K_BRANCH) && (a_q != b_q)) |=> $stable(pc_q));
endmodule

// File: tb/mc_core_bench.sv
module mc_core_bench;
  localparam int MW  = 128;
  localparam int MAW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_we = 1'b0;
  logic [MAW-1:0]  ld_addr = '0;
  logic [31:0]     ld_data = '0;
  logic [MAW-1:0]  pk_addr = '0;
  logic [31:0]     pk_data;
  logic [31:0]     pc;
  logic            retire;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] img [MW];
  logic [31:0] mm  [MW];
  logic [31:0] mr  [32];

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  mc_core u_mc_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pk_addr(pk_addr), .pk_data(pk_data), .pc(pc), .retire(retire)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // 0 reg-op, 1 load, 2 store, 3 branch, 4 undefined
  function automatic int kind_of(input logic [31:0] w);
    if (w[31:26] == 6'h00)
      return (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) ? 0 : 4;
    if (w[31:26] == 6'h23) return 1;
    if (w[31:26] == 6'h2B) return 2;
    if (w[31:26] == 6'h04) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] m_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      default: return (($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
    endcase
  endfunction

  function automatic logic [31:0] m_sx(input logic [15:0] v);
    return 32'($signed(v));
  endfunction

  task automatic model_run(output int n, output int cyc);
    logic [31:0] p, w, a, b, ea;
    n = 0; cyc = 0; p = 0;
    for (int i = 0; i < MW; i++) mm[i] = img[i];
    for (int i = 0; i < 32; i++) mr[i] = 0;
    for (int k = 0; k < 2000; k++) begin
      w = mm[int'(p[MAW+1:2])];
      if (w == HALT) break;
      p = p + 4;
      a = mr[w[25:21]];
      b = mr[w[20:16]];
      ea = a + m_sx(w[15:0]);
      n++;
      case (kind_of(w))
        0: begin cyc += 4; if (w[15:11] != 0) mr[w[15:11]] = m_op(w[5:0], a, b); end
        1: begin cyc += 5; if (w[20:16] != 0) mr[w[20:16]] = mm[int'(ea[MAW+1:2])]; end
        2: begin cyc += 4; mm[int'(ea[MAW+1:2])] = b; end
        3: begin cyc += 3; if (a == b) p = p + (m_sx(w[15:0]) << 2); end
        default: cyc += 2;
      endcase
    end
  endtask

  // per-word requirement tag for the directed program's result area
  function automatic string dir_tag(input int i);
    case (i)
      0: return "R8";
      1, 2, 12: return "R4";
      9, 10: return "R9";
      11: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic run_prog(input bit directed, input int nstore);
    int exp_n, exp_cyc, cyc, nret, dbl;
    bit prev;
    model_run(exp_n, exp_cyc);
    rst_n = 1'b0;
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = MAW'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    pk_addr = MAW'(80);
    #1;
    chk(pk_data == img[80], "R10 peek after load", pk_data, img[80]);
    chk(pc == 32'd0, "R1 pc in reset", pc, 32'd0);
    chk(retire == 1'b0, "R1 retire in reset", {31'd0, retire}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; nret = 0; dbl = 0; prev = 1'b0;
    forever begin
      #1;
      cyc++;
      if (cyc == 1) chk(pc == 32'd0, "R1 first fetch address", pc, 32'd0);
      if (cyc == 2) chk(pc == 32'd4, "R2 pc after fetch", pc, 32'd4);
      if (retire) begin
        if (prev) dbl++;
        nret++;
      end
      prev = retire;
      if (nret == exp_n) break;
      if (cyc > 5000) begin
        chk(1'b0, "R7 run did not finish", 32'(nret), 32'(exp_n));
        break;
      end
      @(negedge clk);
    end
    chk(cyc == exp_cyc, "R7 total cycles", 32'(cyc), 32'(exp_cyc));
    chk(dbl == 0, "R11 retire held two cycles", 32'(dbl), 32'd0);
    @(negedge clk);
    for (int i = 0; i < nstore; i++) begin
      pk_addr = MAW'(96 + i);
      #1;
      chk(pk_data == mm[96 + i], directed ? dir_tag(i) : "R3 random ops", pk_data, mm[96 + i]);
    end
    if (directed) begin
      pk_addr = MAW'(82);
      #1;
      chk(pk_data == 32'h12345678, "R5 store negative offset", pk_data, 32'h12345678);
      pk_addr = MAW'(99);
      #1;
      chk(pk_data == 32'd1, "R3 signed slt", pk_data, 32'd1);
      pk_addr = MAW'(107);
      #1;
      chk(pk_data == 32'd0, "R6 skipped instruction", pk_data, 32'd0);
    end
  endtask

  task automatic build_directed();
    for (int i = 0; i < MW; i++) img[i] = 32'd0;
    img[0]  = enc_i(6'h23, 0, 1, 320);
    img[1]  = enc_i(6'h23, 0, 2, 324);
    img[2]  = enc_r(1, 2, 3, 6'h2A);
    img[3]  = enc_r(2, 1, 4, 6'h2A);
    img[4]  = enc_r(2, 1, 5, 6'h22);
    img[5]  = enc_r(1, 2, 6, 6'h20);
    img[6]  = enc_r(1, 2, 7, 6'h24);
    img[7]  = enc_r(1, 2, 8, 6'h25);
    img[8]  = enc_r(1, 2, 0, 6'h20);
    img[9]  = enc_i(6'h23, 0, 0, 324);
    img[10] = enc_i(6'h3F, 1, 9, 16'h0044);
    img[11] = enc_r(1, 2, 10, 6'h3F);
    img[12] = enc_i(6'h04, 1, 2, 5);
    img[13] = enc_i(6'h04, 2, 2, 1);
    img[14] = enc_r(1, 1, 11, 6'h20);
    img[15] = enc_i(6'h23, 0, 13, 328);
    img[16] = enc_i(6'h23, 13, 12, -8);
    img[17] = enc_i(6'h2B, 13, 12, -12);
    for (int r = 0; r <= 12; r++) img[18 + r] = enc_i(6'h2B, 0, r, 384 + 4 * r);
    img[31] = HALT;
    img[80] = 32'hFFFF_FFF0;
    img[81] = 32'd5;
    img[82] = 32'd340;
    img[83] = 32'h1234_5678;
  endtask

  task automatic build_random();
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    for (int i = 0; i < MW; i++) img[i] = 32'd0;
    for (int r = 1; r <= 8; r++) img[r - 1] = enc_i(6'h23, 0, r, 320 + 4 * (r - 1));
    for (int k = 0; k < 20; k++)
      img[8 + k] = enc_r(int'($urandom_range(8)), int'($urandom_range(8)),
                         int'($urandom_range(8)), fns[$urandom_range(4)]);
    for (int r = 0; r <= 8; r++) img[28 + r] = enc_i(6'h2B, 0, r, 384 + 4 * r);
    img[37] = HALT;
    for (int d = 80; d < 96; d++) img[d] = $urandom;
    img[81] = img[80];
    img[82] = 32'h8000_0000;
    img[83] = 32'h7FFF_FFFF;
  endtask

  initial begin
    void'($urandom(32'd1234));
    build_directed();
    run_prog(1'b1, 13);
    for (int s = 0; s < 4; s++) begin
      build_random();
      run_prog(1'b0, 9);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule